// File: doc/BRIEF.md
# Pipelined Dot-Product Accumulator with Partial-Sum Fold

This block sums a stream of signed integer products into a dot product through an adder pipeline of `STAGES` registers. Each accepted product is added to the partial sum leaving the last pipeline register, and the new sum enters the first one. The ring therefore carries `STAGES` interleaved partial sums at once. A product accepted when the slot pointer reads `k` lands in slot `k`, and the pointer steps by one every cycle, wrapping after `STAGES - 1`.

A collapse command ends the dot product. In fold mode (`multi_i` low when the command is taken), a snapshot of all slots is reduced by pairwise adds. The strides run `STAGES/2`, `STAGES/4`, down to 1, and each level waits out one adder latency of `STAGES` cycles. The single total is then issued with a one-cycle `done_o`. In slot mode (`multi_i` high), no reduction takes place. Instead, each slot is emitted on its own over `STAGES` consecutive cycles, tagged with its index. This lets the block hold `STAGES` independent dot products.

A clear command empties every slot before a new dot product. `busy_o` marks the cycles in which a collapse or slot readout is in progress.

Top module: `dot_fold_acc`

## Requirements
- R1: While reset is held, and after reset until the first command, `done_o` and `busy_o` are low.
- R2: In fold mode, the value issued with `done_o` equals the two's-complement sum, sign-extended to `ACC_W` bits, of every product accepted since the last clear.
- R3: The slot pointer starts at 0 in the cycle after a clear and advances by one each cycle modulo `STAGES`. A product accepted while the pointer reads `k` is added to slot `k`.
- R4: `done_o` of a fold is high exactly `STAGES * log2(STAGES)` cycles after the clock edge that takes the collapse command. This is within the bound `STAGES * (log2(STAGES) + 1)`.
- R5: In fold mode, `done_o` is high for a single cycle per collapse.
- R6: `busy_o` is high from the edge after an accepted collapse until the result is issued. A product presented in the collapse cycle or while `busy_o` is high is discarded, and the slots keep their contents.
- R7: A collapse command while `busy_o` is high is ignored and produces no extra result.
- R8: Clear zeroes all slots, resets the pointer and aborts any collapse in progress. `busy_o` and `done_o` are low in the following cycle, and no result of the aborted collapse is issued.
- R9: In slot mode, the block issues `STAGES` consecutive `done_o` cycles, starting one edge after the command. The first carries the slot index the pointer holds after the command edge, and each later one carries the next index. Each cycle presents that slot's sum on `res_o` and its index on `res_idx_o`. The readout leaves the slots unchanged.
- R10: Dot products shorter than `STAGES` (some slots remain zero) and longer than `STAGES` (slots wrap and accumulate more than once) give correct sums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Zero all slots and abort any collapse |
| in_vld_i | input | 1 | Product on `prod_i` is valid this cycle |
| prod_i | input | DATA_W | Signed product to accumulate |
| collapse_i | input | 1 | End the dot product and start fold or slot readout |
| multi_i | input | 1 | Sampled with `collapse_i`: 0 fold to one sum, 1 read slots separately |
| res_o | output | ACC_W | Signed result or slot sum |
| res_idx_o | output | log2(STAGES) | Slot index in slot mode, 0 for a fold result |
| done_o | output | 1 | Result on `res_o` is valid |
| busy_o | output | 1 | Collapse or slot readout in progress |

## Verification
The bench aims at vectors shorter than the ring, longer than it, and filled with the most negative product, where a wrong sign extension or a skipped fold level shows up as a bad total. It drives products during the collapse cycle and while busy, then collapses the same data a second time. A design that let one of those products in gives two different totals. A repeated collapse during busy, and a clear in the middle of a fold, would produce a stray result that the scoreboard rejects. In slot mode, the index and cycle of every pulse are checked, so an off-by-one pointer or a readout that alters the slots fails the second pass.

// File: rtl/dfa_pkg.sv
package dfa_pkg;

  // How a collapse command reads the ring out.
  typedef enum logic {
    READ_FOLD  = 1'b0,
    READ_SLOTS = 1'b1
  } read_mode_e;

  // Worst-case cycles allowed for a fold of s slots.
  function automatic int collapse_bound(input int s);
    return s * ($clog2(s) + 1);
  endfunction

endpackage

// File: rtl/dfa_ring.sv
// Adder pipeline closed into a ring: the sum leaving the last register
// is added to the incoming product and re-enters the first register.
module dfa_ring #(
  parameter int STAGES = 4,
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       add_en_i,
  input  logic [DATA_W-1:0]          prod_i,
  output logic [ACC_W-1:0]           tap_o,
  output logic [$clog2(STAGES)-1:0]  slot_o,
  output logic [STAGES*ACC_W-1:0]    flat_o
);
  localparam int IW = $clog2(STAGES);

  logic [ACC_W-1:0] stage_q [STAGES];
  logic [ACC_W-1:0] stage_d [STAGES];
  logic [IW-1:0]    ptr_q, ptr_d;
  logic [ACC_W-1:0] addend;

  always_comb begin
    addend = add_en_i ? {{(ACC_W-DATA_W){prod_i[DATA_W-1]}}, prod_i} : '0;
    for (int i = 0; i < STAGES; i++) begin
      if (clr_i)       stage_d[i] = '0;
      else if (i == 0) stage_d[i] = stage_q[STAGES-1] + addend;
      else             stage_d[i] = stage_q[i-1];
    end
    if (clr_i || ptr_q == IW'(STAGES-1)) ptr_d = '0;
    else                                 ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      ptr_q <= ptr_d;
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_flat
      assign flat_o[g*ACC_W +: ACC_W] = stage_q[g];
    end
  endgenerate

  assign tap_o  = stage_q[STAGES-1];
  assign slot_o = ptr_q;
endmodule

// File: rtl/dfa_fold.sv
// Pairwise reduction of a slot snapshot: strides STAGES/2 .. 1,
// each level held for one adder latency of STAGES cycles.
module dfa_fold #(
  parameter int STAGES = 4,
  parameter int ACC_W  = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    abort_i,
  input  logic                    start_i,
  input  logic [STAGES*ACC_W-1:0] snap_i,
  output logic                    run_o,
  output logic [ACC_W-1:0]        res_o,
  output logic                    done_o
);
  localparam int LV = $clog2(STAGES);
  localparam int WW = LV;
  localparam int LW = $clog2(LV + 1);

  logic             run_q, run_d;
  logic [WW-1:0]    wait_q, wait_d;
  logic [LW-1:0]    lvl_q, lvl_d;
  logic             done_q, done_d;
  logic [ACC_W-1:0] res_q, res_d;
  logic [ACC_W-1:0] fold_q [STAGES];
  logic [ACC_W-1:0] fold_d [STAGES];
  logic             load_en;
  int               stride;

  always_comb begin
    run_d  = run_q;
    wait_d = wait_q;
    lvl_d  = lvl_q;
    res_d  = res_q;
    done_d = 1'b0;
    fold_d = fold_q;
    stride = STAGES >> (int'(lvl_q) + 1);
    if (abort_i) begin
      run_d = 1'b0;
    end else if (start_i && !run_q) begin
      run_d  = 1'b1;
      wait_d = '0;
      lvl_d  = '0;
      for (int i = 0; i < STAGES; i++) fold_d[i] = snap_i[i*ACC_W +: ACC_W];
    end else if (run_q) begin
      if (wait_q == WW'(STAGES-1)) begin
        wait_d = '0;
        lvl_d  = lvl_q + 1'b1;
        for (int i = 0; i < STAGES; i++)
          if (i < stride) fold_d[i] = fold_q[i] + fold_q[i+stride];
        if (lvl_q == LW'(LV-1)) begin
          run_d  = 1'b0;
          done_d = 1'b1;
          res_d  = fold_q[0] + fold_q[1];
        end
      end else begin
        wait_d = wait_q + 1'b1;
      end
    end
  end

  assign load_en = start_i | run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wait_q <= '0;
      lvl_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      wait_q <= wait_d;
      lvl_q  <= lvl_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      for (int i = 0; i < STAGES; i++) fold_q[i] <= fold_d[i];
    end
    if (done_d) res_q <= res_d;
  end

  assign run_o  = run_q;
  assign res_o  = res_q;
  assign done_o = done_q;
endmodule

// File: rtl/dot_fold_acc.sv
module dot_fold_acc
  import dfa_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      in_vld_i,
  input  logic [DATA_W-1:0]         prod_i,
  input  logic                      collapse_i,
  input  logic                      multi_i,
  output logic [ACC_W-1:0]          res_o,
  output logic [$clog2(STAGES)-1:0] res_idx_o,
  output logic                      done_o,
  output logic                      busy_o
);
  localparam int IW = $clog2(STAGES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                    cmd_ok, fold_go, slot_go, add_en;
  logic                    fold_run, fold_done;
  logic [ACC_W-1:0]        fold_res, tap;
  logic [IW-1:0]           tap_slot;
  logic [STAGES*ACC_W-1:0] snap;
  read_mode_e              mode;

  logic             drain_q, drain_d;
  logic [IW-1:0]    dcnt_q, dcnt_d;
  logic             ddone_q, ddone_d;
  logic [ACC_W-1:0] dres_q, dres_d;
  logic [IW-1:0]    didx_q, didx_d;

  assign busy_o  = fold_run | drain_q;
  assign mode    = read_mode_e'(multi_i);
  assign cmd_ok  = collapse_i & ~busy_o & ~clr_i;
  assign fold_go = cmd_ok & (mode == READ_FOLD);
  assign slot_go = cmd_ok & (mode == READ_SLOTS);
  assign add_en  = in_vld_i & ~busy_o & ~collapse_i;

  dfa_ring #(.STAGES(STAGES), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr_i    (clr_i),
    .add_en_i (add_en),
    .prod_i   (prod_i),
    .tap_o    (tap),
    .slot_o   (tap_slot),
    .flat_o   (snap)
  );

  dfa_fold #(.STAGES(STAGES), .ACC_W(ACC_W)) u_fold (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .abort_i (clr_i),
    .start_i (fold_go),
    .snap_i  (snap),
    .run_o   (fold_run),
    .res_o   (fold_res),
    .done_o  (fold_done)
  );

  // slot readout: one slot per cycle as the ring turns past the tap
  always_comb begin
    drain_d = drain_q;
    dcnt_d  = dcnt_q;
    ddone_d = 1'b0;
    dres_d  = dres_q;
    didx_d  = didx_q;
    if (clr_i) begin
      drain_d = 1'b0;
    end else if (slot_go) begin
      drain_d = 1'b1;
      dcnt_d  = '0;
    end else if (drain_q) begin
      ddone_d = 1'b1;
      dres_d  = tap;
      didx_d  = tap_slot;
      dcnt_d  = dcnt_q + 1'b1;
      if (dcnt_q == IW'(STAGES-1)) drain_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      drain_q <= 1'b0;
      dcnt_q  <= '0;
      ddone_q <= 1'b0;
    end else begin
      drain_q <= drain_d;
      dcnt_q  <= dcnt_d;
      ddone_q <= ddone_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ddone_d) begin
      dres_q <= dres_d;
      didx_q <= didx_d;
    end
  end

  assign done_o    = fold_done | ddone_q;
  assign res_o     = fold_done ? fold_res : dres_q;
  assign res_idx_o = fold_done ? '0 : didx_q;
endmodule

// File: rtl/dfa_check.sv
module dfa_check
  import dfa_pkg::*;
#(
  parameter int STAGES = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      clr_i,
  input logic                      collapse_i,
  input logic                      multi_i,
  input logic                      done_o,
  input logic                      busy_o,
  input logic [$clog2(STAGES)-1:0] tap_slot
);
  localparam int IW    = $clog2(STAGES);
  localparam int BOUND = collapse_bound(STAGES);

  logic          mode_q;
  logic [7:0]    bcnt_q;
  logic [IW-1:0] slot_nxt;

  assign slot_nxt = (tap_slot == IW'(STAGES-1)) ? '0 : tap_slot + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      bcnt_q <= '0;
    end else begin
      if (collapse_i && !busy_o && !clr_i) mode_q <= multi_i;
      bcnt_q <= busy_o ? bcnt_q + 8'd1 : 8'd0;
    end
  end

  p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> tap_slot == $past(slot_nxt));

  p_fold_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= 8'(BOUND));

  p_busy_end_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !$past(clr_i)) |-> done_o);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !mode_q) |=> !done_o);

  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  p_busy_on_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (collapse_i && !busy_o && !clr_i) |=> busy_o);

  p_clr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!busy_o && !done_o));
endmodule

bind dot_fold_acc dfa_check #(.STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .clr_i      (clr_i),
  .collapse_i (collapse_i),
  .multi_i    (multi_i),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .tap_slot   (tap_slot)
);

// File: tb/dot_fold_acc_tb.sv
`timescale 1ns/1ps
module dot_fold_acc_tb;
  localparam int S  = 4;
  localparam int DW = 16;
  localparam int AW = 40;
  localparam int LV = $clog2(S);

  logic          clk, rst_n, clr, vld, coll, multi;
  logic [DW-1:0] prod;
  logic [AW-1:0] res_o;
  logic [LV-1:0] res_idx_o;
  logic          done_o, busy_o;

  dot_fold_acc #(.STAGES(S), .DATA_W(DW), .ACC_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .in_vld_i(vld), .prod_i(prod),
    .collapse_i(coll), .multi_i(multi), .res_o(res_o), .res_idx_o(res_idx_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  typedef struct {
    longint val;
    int     idx;
    int     edge_n;
    string  tag;
  } exp_t;

  exp_t   sb[$];
  longint slot_m[S];
  int     ptr_m;
  int     cyc;
  int     checks, errors;
  bit     fin;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7", "unexpected done", 1, 0);
      end else begin
        e = sb.pop_front();
        chk(longint'($signed(res_o)) == e.val, e.tag, "result",
            longint'($signed(res_o)), e.val);
        chk(int'(res_idx_o) == e.idx, "R3", "slot index", res_idx_o, e.idx);
        chk(cyc == e.edge_n, "R4", "done cycle", cyc, e.edge_n);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    ptr_m = clr ? 0 : (ptr_m + 1) % S;
    @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    tick();
    clr = 1'b0;
    for (int i = 0; i < S; i++) slot_m[i] = 0;
  endtask

  task automatic feed(input int n, input bit most_neg);
    for (int k = 0; k < n; k++) begin
      vld  = 1'b1;
      prod = most_neg ? 16'h8000 : DW'($urandom);
      slot_m[ptr_m] += longint'($signed(prod));
      tick();
    end
    vld = 1'b0;
  endtask

  // fold-mode collapse; junk=1 drives products that must be discarded
  task automatic fold_run(input bit junk, input string tag);
    exp_t   e;
    longint tot = 0;
    for (int i = 0; i < S; i++) tot += slot_m[i];
    e.val = tot; e.idx = 0; e.edge_n = cyc + 1 + LV * S; e.tag = tag;
    sb.push_back(e);
    coll = 1'b1; multi = 1'b0;
    vld = junk; prod = DW'($urandom);
    tick();
    coll = 1'b0;
    chk(busy_o == 1'b1, "R6", "busy after collapse", busy_o, 1);
    while (busy_o) begin
      vld = junk; prod = DW'($urandom);
      tick();
    end
    vld = 1'b0;
    tick();
    chk(done_o == 1'b0, "R5", "done width", done_o, 0);
  endtask

  task automatic slot_run();
    exp_t e;
    int   base = (ptr_m + 1) % S;
    int   ce   = cyc + 1;
    for (int j = 0; j < S; j++) begin
      e.val = slot_m[(base + j) % S]; e.idx = (base + j) % S;
      e.edge_n = ce + 1 + j; e.tag = "R9";
      sb.push_back(e);
    end
    coll = 1'b1; multi = 1'b1;
    tick();
    coll = 1'b0; multi = 1'b0;
    while (busy_o) tick();
    tick();
  endtask

  initial begin
    exp_t e;
    rst_n = 1'b0; clr = 1'b0; vld = 1'b0; coll = 1'b0; multi = 1'b0;
    prod = '0; ptr_m = 0; cyc = 0; checks = 0; errors = 0; fin = 1'b0;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R1", "idle in reset", {done_o, busy_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R1", "idle after reset", {done_o, busy_o}, 0);

    // R10: shorter than the ring, then longer
    do_clear(); feed(3, 1'b0);  fold_run(1'b0, "R10");
    do_clear(); feed(11, 1'b0); fold_run(1'b0, "R10");
    // R2: most negative products, sign extension
    do_clear(); feed(12, 1'b1); fold_run(1'b0, "R2");
    do_clear(); feed(1, 1'b0);  fold_run(1'b0, "R2");

    // R6: junk products in collapse cycle and while busy, then same total again
    do_clear(); feed(8, 1'b0);
    fold_run(1'b1, "R6");
    fold_run(1'b0, "R6");

    // R7: second collapse while busy yields no extra result
    do_clear(); feed(6, 1'b0);
    begin
      longint tot = 0;
      for (int i = 0; i < S; i++) tot += slot_m[i];
      e.val = tot; e.idx = 0; e.edge_n = cyc + 1 + LV * S; e.tag = "R7";
      sb.push_back(e);
    end
    coll = 1'b1; tick(); coll = 1'b0; tick();
    coll = 1'b1; multi = 1'b1; tick(); coll = 1'b0; multi = 1'b0;
    while (busy_o) tick();
    repeat (2 * S) tick();

    // R8: clear aborts a fold, then everything reads zero
    do_clear(); feed(5, 1'b0);
    coll = 1'b1; tick(); coll = 1'b0; tick(); tick();
    do_clear();
    chk(busy_o == 1'b0 && done_o == 1'b0, "R8", "idle after clear", {busy_o, done_o}, 0);
    repeat (2 * LV * S) tick();
    fold_run(1'b0, "R8");

    // R9 / R3: slot readout twice, then fold the same data
    do_clear(); feed(10, 1'b0);
    slot_run();
    repeat (3) tick();
    slot_run();
    fold_run(1'b0, "R2");

    repeat (4) tick();
    chk(sb.size() == 0, "R7", "results outstanding", sb.size(), 0);
    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule